// File: doc/BRIEF.md
# Indirect Register-to-Peripheral-Bus Bridge

The block sits behind a host register port that only ever moves full 64-bit words. It turns a small set of registers into single read or write transfers on a narrow, byte-addressed peripheral bus. The host selects a register by a word index, which is its byte address with the low three bits dropped. Software first writes a command word that carries the direction, a byte count and a 32-bit target address.

A read starts as soon as a command with the read flag is written. The returned bytes land in the data register. A write starts when the data register is written while the stored command selects the write direction. Short transfers are not right-justified. Their bytes sit in the 64-bit data register at the lane that matches the target address offset within an aligned 8-byte sector.

The peripheral side is a request/acknowledge port. The request and its fields stay steady until the acknowledge arrives. The host side holds its ready low for the whole transfer. A status register always reports done. Several housekeeping indices accept writes and read as zero.

Top module: `xbb_bridge`

## Requirements
- R1: The register index is host_addr shifted right by 3, so host_addr[2:0] has no effect. Index 0x41 is the command, 0x42 is the data and 0x43 is the status register. A host read accepted on a clock edge (host_valid and host_ready high, host_we low) presents its word on host_rdata with host_rvalid high for the following cycle.
- R2: The command and data registers read back the last value written or loaded. Both read as zero after reset.
- R3: The status register always reads 0x8000_0000_0000_0000, that is only the most significant bit set, meaning done. Writes to it change nothing.
- R4: Indices 0x40, 0x12, 0x13, 0x18 and every other unlisted index read as zero. A write to any of them changes neither the command nor the data register and starts no transfer.
- R5: Command encoding, with bit 63 the most significant bit. Bit 63 set selects a read and clear selects a write. Bits 58:52 hold the byte count. Bits 31:0 hold the target address. All other bits are ignored.
- R6: Writing a command with the read flag and a legal size starts one bus read. From the next cycle per_req is high with per_we low, per_addr equal to the address field and per_size equal to the byte count.
- R7: At the read acknowledge the data register is loaded with a word built in two steps. First, per_rdata is masked to its N most significant bytes, where N is the size. Then the result is shifted right by 8 times address bits 2:0.
- R8: A data-register write always stores the value. If the stored command selects a write and has a legal size, one bus write starts with per_we high, the stored address and size, and per_wdata equal to the written value shifted right by 8 times address bits 2:0. The peripheral takes the N most significant bytes of per_wdata, first byte at the address.
- R9: Legal sizes are 1, 2, 4 and 8. Any other count, zero included, starts no transfer. A rejected read leaves the data register unchanged.
- R10: While a transfer is outstanding, host_ready is low and per_req and its fields hold steady. On the cycle after per_ack, per_req is low and host_ready is high.
- R11: Writing a command with the write direction starts no transfer by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_addr | input | HOST_AW | Host byte address |
| host_wdata | input | 64 | Host write word |
| host_ready | output | 1 | Bridge can accept an access |
| host_rdata | output | 64 | Read word |
| host_rvalid | output | 1 | host_rdata valid this cycle |
| per_req | output | 1 | Peripheral transfer request, held until acknowledge |
| per_we | output | 1 | Transfer is a write |
| per_addr | output | 32 | Peripheral byte address |
| per_size | output | 4 | Byte count (1, 2, 4 or 8) |
| per_wdata | output | 64 | Write bytes, first byte in the most significant lane |
| per_ack | input | 1 | Peripheral acknowledge |
| per_rdata | input | 64 | Read bytes, first byte in the most significant lane |

## Verification
Reads are tried with every legal size at sector offsets 0, 3, 4, 6 and 7, using a peripheral word whose bytes all differ. This distinguishes a wrong mask, a wrong shift direction and a shift by bits instead of bytes. Writes at offsets 0, 2 and 7 show whether the placement shifts right, and whether the stored address and size are the ones sent. Illegal counts 0, 3, 6, 9 and 16 show that a rejected read leaves the data register alone while a rejected write still stores it. A slow acknowledge measures exactly how long the host stays stalled.

// File: rtl/xbb_pkg.sv
package xbb_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned NBYTES   = DATA_W / 8;
  localparam int unsigned SZ_W     = $clog2(NBYTES) + 1;
  localparam int unsigned OFF_W    = $clog2(NBYTES);
  localparam int unsigned BUS_AW   = 32;
  localparam int unsigned CNT_W    = 7;

  // command word layout (bit DATA_W-1 is the most significant bit)
  localparam int unsigned CMD_RD_BIT  = 63;
  localparam int unsigned CMD_CNT_LSB = 52;

  localparam int unsigned IDX_BASE   = 'h40;
  localparam int unsigned IDX_CMD    = 'h41;
  localparam int unsigned IDX_DATA   = 'h42;
  localparam int unsigned IDX_STATUS = 'h43;

  localparam logic [DATA_W-1:0] STATUS_DONE = {1'b1, {(DATA_W-1){1'b0}}};

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_BUSY = 1'b1} xfer_state_e;

  typedef struct packed {
    logic              is_read;
    logic [CNT_W-1:0]  count;
    logic [BUS_AW-1:0] addr;
    logic              count_ok;
  } cmd_fields_t;
endpackage

// File: rtl/xbb_rst_sync.sv
module xbb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xbb_cmd_decode.sv
module xbb_cmd_decode
  import xbb_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  output cmd_fields_t       fields
);
  logic [CNT_W-1:0] cnt;
  logic             unused_cmd_bits;

  assign cnt = word[CMD_CNT_LSB +: CNT_W];
  assign unused_cmd_bits = ^{word[CMD_RD_BIT-1:CMD_CNT_LSB+CNT_W],
                             word[CMD_CNT_LSB-1:BUS_AW]};

  always_comb begin
    fields.is_read  = word[CMD_RD_BIT];
    fields.count    = cnt;
    fields.addr     = word[BUS_AW-1:0];
    fields.count_ok = (cnt != '0) && ((cnt & (cnt - 1'b1)) == '0)
                      && (cnt <= CNT_W'(NBYTES));
  end
endmodule

// File: rtl/xbb_lane_align.sv
module xbb_lane_align
  import xbb_pkg::*;
(
  input  logic [DATA_W-1:0] rd_raw,
  input  logic [SZ_W-1:0]   rd_size,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic [DATA_W-1:0] wr_src,
  input  logic [OFF_W-1:0]  wr_off,
  output logic [DATA_W-1:0] rd_placed,
  output logic [DATA_W-1:0] wr_placed
);
  logic [DATA_W-1:0] rd_masked;

  // lane g holds the g-th byte of the transfer, most significant first
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign rd_masked[DATA_W-1-8*g -: 8] =
      (SZ_W'(g) < rd_size) ? rd_raw[DATA_W-1-8*g -: 8] : 8'h00;
  end

  assign rd_placed = rd_masked >> {rd_off, 3'b000};
  assign wr_placed = wr_src    >> {wr_off, 3'b000};
endmodule

// File: rtl/xbb_bridge.sv
module xbb_bridge
  import xbb_pkg::*;
#(
  parameter int unsigned HOST_AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [63:0]        host_wdata,
  output logic               host_ready,
  output logic [63:0]        host_rdata,
  output logic               host_rvalid,
  output logic               per_req,
  output logic               per_we,
  output logic [31:0]        per_addr,
  output logic [3:0]         per_size,
  output logic [63:0]        per_wdata,
  input  logic               per_ack,
  input  logic [63:0]        per_rdata
);
  localparam int unsigned IDX_W = HOST_AW - 3;

  logic rst_q_n;
  xbb_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  logic [IDX_W-1:0] idx;
  logic             unused_lowbits;
  assign idx            = host_addr[HOST_AW-1:3];
  assign unused_lowbits = ^host_addr[2:0];

  xfer_state_e       state_q, state_d;
  logic [DATA_W-1:0] cmd_q, cmd_d, data_q, data_d, rdata_q, rdata_d, wdata_q, wdata_d;
  logic              req_q, req_d, we_q, we_d, rvalid_q, rvalid_d;
  logic [BUS_AW-1:0] addr_q, addr_d;
  logic [SZ_W-1:0]   size_q, size_d;
  logic              cmd_en, data_en, rdata_en, xfer_en;

  cmd_fields_t f_new, f_cur;
  xbb_cmd_decode u_dec_new (.word(host_wdata), .fields(f_new));
  xbb_cmd_decode u_dec_cur (.word(cmd_q),      .fields(f_cur));

  logic [DATA_W-1:0] rd_placed, wr_placed;
  xbb_lane_align u_align (
    .rd_raw   (per_rdata),
    .rd_size  (size_q),
    .rd_off   (addr_q[OFF_W-1:0]),
    .wr_src   (host_wdata),
    .wr_off   (f_cur.addr[OFF_W-1:0]),
    .rd_placed(rd_placed),
    .wr_placed(wr_placed)
  );

  logic acc, wr_cmd, wr_dat, launch_rd, launch_wr, done;
  assign host_ready = (state_q == ST_IDLE);
  assign acc        = host_valid && host_ready;
  assign wr_cmd     = acc && host_we && (idx == IDX_W'(IDX_CMD));
  assign wr_dat     = acc && host_we && (idx == IDX_W'(IDX_DATA));
  assign launch_rd  = wr_cmd && f_new.is_read && f_new.count_ok;
  assign launch_wr  = wr_dat && !f_cur.is_read && f_cur.count_ok;
  assign done       = (state_q == ST_BUSY) && per_ack;

  // next state
  always_comb begin
    state_d  = state_q;
    req_d    = req_q;
    we_d     = we_q;
    addr_d   = addr_q;
    size_d   = size_q;
    wdata_d  = wdata_q;
    xfer_en  = 1'b0;
    cmd_en   = wr_cmd;
    cmd_d    = host_wdata;
    data_en  = 1'b0;
    data_d   = host_wdata;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_dat) data_en = 1'b1;
        if (launch_rd || launch_wr) begin
          xfer_en = 1'b1;
          state_d = ST_BUSY;
          req_d   = 1'b1;
          we_d    = launch_wr;
          addr_d  = launch_rd ? f_new.addr : f_cur.addr;
          size_d  = launch_rd ? SZ_W'(f_new.count) : SZ_W'(f_cur.count);
          wdata_d = launch_wr ? wr_placed : '0;
        end
      end
      ST_BUSY: begin
        if (per_ack) begin
          xfer_en = 1'b1;
          state_d = ST_IDLE;
          req_d   = 1'b0;
          if (!we_q) begin
            data_en = 1'b1;
            data_d  = rd_placed;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rdata_en = acc && !host_we;
    rvalid_d = rdata_en;
    if      (idx == IDX_W'(IDX_CMD))    rdata_d = cmd_q;
    else if (idx == IDX_W'(IDX_DATA))   rdata_d = data_q;
    else if (idx == IDX_W'(IDX_STATUS)) rdata_d = STATUS_DONE;
    else                                rdata_d = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q  <= ST_IDLE;
      req_q    <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      size_q   <= '0;
      wdata_q  <= '0;
      cmd_q    <= '0;
      data_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      if (xfer_en || done) begin
        state_q <= state_d;
        req_q   <= req_d;
      end
      if (xfer_en && state_q == ST_IDLE) begin
        we_q    <= we_d;
        addr_q  <= addr_d;
        size_q  <= size_d;
        wdata_q <= wdata_d;
      end
      if (cmd_en)   cmd_q   <= cmd_d;
      if (data_en)  data_q  <= data_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
  assign per_req     = req_q;
  assign per_we      = we_q;
  assign per_addr    = addr_q;
  assign per_size    = size_q;
  assign per_wdata   = wdata_q;
endmodule

// File: rtl/xbb_bridge_chk.sv
module xbb_bridge_chk #(
  parameter int unsigned HOST_AW = 16
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic               host_valid,
  input logic               host_we,
  input logic [HOST_AW-1:0] host_addr,
  input logic [63:0]        host_wdata,
  input logic               host_ready,
  input logic [63:0]        host_rdata,
  input logic               host_rvalid,
  input logic               per_req,
  input logic               per_we,
  input logic [31:0]        per_addr,
  input logic [3:0]         per_size,
  input logic [63:0]        per_wdata,
  input logic               per_ack
);
  logic [HOST_AW-4:0] cidx;
  logic               rd_acc;
  assign cidx   = host_addr[HOST_AW-1:3];
  assign rd_acc = host_valid && host_ready && !host_we;

  p_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_acc |=> host_rvalid);

  p_status_done_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_acc && cidx == (HOST_AW-3)'('h43)) |=> host_rdata == 64'h8000_0000_0000_0000);

  p_noop_zero_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_acc && (cidx == (HOST_AW-3)'('h12) || cidx == (HOST_AW-3)'('h13) ||
                cidx == (HOST_AW-3)'('h18) || cidx == (HOST_AW-3)'('h40)))
    |=> host_rdata == 64'h0);

  p_launch_from_write_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(per_req) |-> $past(host_valid && host_we));

  p_size_legal_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    per_req |-> ($countones(per_size) == 1 && per_size <= 4'd8));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    per_req |-> !host_ready);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (per_req && !per_ack) |=> (per_req && $stable(per_addr) && $stable(per_size)
                              && $stable(per_we) && $stable(per_wdata)));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (per_req && per_ack) |=> (!per_req && host_ready));

  p_cmd_write_idle_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (host_valid && host_ready && host_we && cidx == (HOST_AW-3)'('h41) && !host_wdata[63])
    |=> !per_req);
endmodule

bind xbb_bridge xbb_bridge_chk #(.HOST_AW(HOST_AW)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .host_valid(host_valid), .host_we(host_we),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
  .host_rdata(host_rdata), .host_rvalid(host_rvalid), .per_req(per_req),
  .per_we(per_we), .per_addr(per_addr), .per_size(per_size),
  .per_wdata(per_wdata), .per_ack(per_ack)
);

// File: tb/xbb_bridge_tb_top.sv
`timescale 1ns/1ps
module xbb_bridge_tb_top;
  localparam int unsigned AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_valid = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [63:0]   host_wdata = '0;
  logic          host_ready, host_rvalid;
  logic [63:0]   host_rdata;
  logic          per_req, per_we;
  logic [31:0]   per_addr;
  logic [3:0]    per_size;
  logic [63:0]   per_wdata;
  logic          per_ack = 1'b0;
  logic [63:0]   per_rdata = '0;

  always #4 clk = ~clk;

  xbb_bridge #(.HOST_AW(AW)) dut_i (.*);

  int n_chk = 0, n_fail = 0;

  // peripheral model
  int          per_lat = 1, per_cnt = 0, req_count = 0;
  logic [63:0] per_src = 64'h1122_3344_5566_7788;
  logic        rec_we;
  logic [31:0] rec_addr;
  logic [3:0]  rec_size;
  logic [63:0] rec_wdata;
  initial forever begin
    @(negedge clk);
    if (per_ack) begin
      per_ack = 1'b0; per_cnt = 0;
    end else if (per_req) begin
      per_cnt++;
      if (per_cnt >= per_lat) begin
        per_ack = 1'b1; per_rdata = per_src; req_count++;
        rec_we = per_we; rec_addr = per_addr; rec_size = per_size; rec_wdata = per_wdata;
      end
    end
  end

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_cmd(logic rd, int cnt, logic [31:0] a);
    return {rd, 4'b0, 7'(cnt), 20'b0, a};
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (!host_ready) @(negedge clk);
  endtask

  task automatic hwr(int idx, logic [63:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b1; host_addr = AW'(idx << 3); host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
    while (!host_ready) @(negedge clk);
  endtask

  task automatic hrd_a(logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b0; host_addr = a;
    while (!host_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    d = host_rvalid ? host_rdata : 64'hDEAD_DEAD_DEAD_DEAD;
  endtask

  task automatic hrd(int idx, output logic [63:0] d);
    hrd_a(AW'(idx << 3), d);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    hrd('h41, d); chk("R2 cmd after reset", d, 64'h0);
    hrd('h42, d); chk("R2 data after reset", d, 64'h0);
  endtask

  task automatic t_status();
    logic [63:0] d;
    int rc = req_count;
    hrd('h43, d); chk("R3 status", d, 64'h8000_0000_0000_0000);
    hwr('h43, 64'h0); hrd('h43, d); chk("R3 status after write", d, 64'h8000_0000_0000_0000);
    chk("R3 no transfer", 64'(req_count), 64'(rc));
  endtask

  task automatic t_noop();
    logic [63:0] d;
    int rc = req_count;
    int idxs[5] = '{'h12, 'h13, 'h18, 'h40, 'h55};
    hwr('h41, mk_cmd(1'b0, 2, 32'h0000_0100));
    hwr('h42, 64'hA5A5_0000_1234_5678);
    rc = req_count;
    foreach (idxs[i]) begin
      hwr(idxs[i], 64'hFFFF_FFFF_FFFF_FFFF);
      hrd(idxs[i], d); chk("R4 noop reads zero", d, 64'h0);
    end
    hrd('h41, d); chk("R4 cmd untouched", d, mk_cmd(1'b0, 2, 32'h0000_0100));
    hrd('h42, d); chk("R4 data untouched", d, 64'hA5A5_0000_1234_5678);
    chk("R4 no transfer", 64'(req_count), 64'(rc));
  endtask

  task automatic t_cmd_rw();
    logic [63:0] d;
    int rc = req_count;
    logic [63:0] c = mk_cmd(1'b0, 4, 32'hCAFE_0003) | 64'h7800_0F00_0000_0000;
    hwr('h41, c);
    hrd('h41, d); chk("R2 cmd readback", d, c);
    chk("R11 write cmd no transfer", 64'(req_count), 64'(rc));
    hrd_a(AW'(('h41 << 3) | 5), d); chk("R1 low address bits ignored", d, c);
  endtask

  task automatic t_read(int cnt, logic [31:0] a);
    logic [63:0] d, mask;
    int rc = req_count;
    mask = ~64'h0 << (64 - 8*cnt);
    hwr('h41, mk_cmd(1'b1, cnt, a));
    wait_idle();
    chk("R6 one read issued", 64'(req_count), 64'(rc + 1));
    chk("R6 per_we low", 64'(rec_we), 64'h0);
    chk("R6 per_addr", 64'(rec_addr), 64'(a));
    chk("R5 per_size", 64'(rec_size), 64'(cnt));
    hrd('h42, d);
    chk("R7 read placement", d, (per_src & mask) >> (8 * a[2:0]));
  endtask

  task automatic t_read_bad();
    logic [63:0] d;
    int rc;
    int bad[5] = '{0, 3, 6, 9, 16};
    hwr('h41, mk_cmd(1'b1, 3, 32'h10));
    hwr('h42, 64'h0BAD_F00D_0BAD_F00D);
    rc = req_count;
    foreach (bad[i]) begin
      hwr('h41, mk_cmd(1'b1, bad[i], 32'h20));
      wait_idle();
      hrd('h42, d); chk("R9 rejected read keeps data", d, 64'h0BAD_F00D_0BAD_F00D);
    end
    chk("R9 no transfer", 64'(req_count), 64'(rc));
  endtask

  task automatic t_write(int cnt, logic [31:0] a, logic [63:0] v);
    logic [63:0] d;
    int rc = req_count;
    hwr('h41, mk_cmd(1'b0, cnt, a));
    hwr('h42, v);
    wait_idle();
    chk("R8 one write issued", 64'(req_count), 64'(rc + 1));
    chk("R8 per_we high", 64'(rec_we), 64'h1);
    chk("R8 per_addr", 64'(rec_addr), 64'(a));
    chk("R8 per_size", 64'(rec_size), 64'(cnt));
    chk("R8 write placement", rec_wdata, v >> (8 * a[2:0]));
    hrd('h42, d); chk("R8 data stored", d, v);
  endtask

  task automatic t_write_bad();
    logic [63:0] d;
    int rc = req_count;
    hwr('h41, mk_cmd(1'b0, 6, 32'h40));
    hwr('h42, 64'h1357_9BDF_2468_ACE0);
    wait_idle();
    chk("R9 rejected write no transfer", 64'(req_count), 64'(rc));
    hrd('h42, d); chk("R9 rejected write still stores", d, 64'h1357_9BDF_2468_ACE0);
  endtask

  task automatic t_busy();
    logic [63:0] d;
    int n = 0;
    per_lat = 5;
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b1; host_addr = AW'('h41 << 3);
    host_wdata = mk_cmd(1'b1, 8, 32'h0000_2000);
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
    chk("R10 per_req raised", 64'(per_req), 64'h1);
    while (!host_ready && n < 50) begin n++; @(negedge clk); end
    chk("R10 stall cycles", 64'(n), 64'd5);
    chk("R10 per_req dropped", 64'(per_req), 64'h0);
    hrd('h42, d); chk("R7 slow read loaded", d, per_src);
    per_lat = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_status();
    t_noop();
    t_cmd_rw();
    t_read(8, 32'h0000_1000);
    t_read(1, 32'h0000_1003);
    t_read(2, 32'h0000_1006);
    t_read(4, 32'h0000_1004);
    t_read(2, 32'h0000_1007);
    t_read_bad();
    t_write(4, 32'h0000_1002, 64'hDEAD_BEEF_0123_4567);
    t_write(1, 32'h0000_3007, 64'hF1E2_D3C4_B5A6_9788);
    t_write(8, 32'hFFFF_FFF8, 64'h0102_0304_0506_0708);
    t_write_bad();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule